// File: doc/BRIEF.md
# Video Power Domain Sequencer

This block brings a video-processing power domain up or down in a fixed, timed order. A one-cycle command pulse starts a sequence. The block then steps a set of level outputs: the domain sleep (power-switch) control, the isolation control, memory power-down bits, a block reset and a clock enable. All waits are counted in pulses of a free-running microsecond tick, so the timing does not depend on the clock frequency. The wait lengths are parameters, which lets simulation use short values.

The memory power-down bits are held in several 32-bit banks. They change two adjacent bits at a time, followed by one group of eight single bits. A short settling wait follows every step. A mode input selects whether two or three banks are stepped. While a sequence runs, `busy` is high. A one-cycle `done` pulse marks the end of the sequence. `dom_on` shows the current state of the domain. All pins are plain control and status levels and there is no streaming data path, so no valid/ready handshake applies.

Top module: `psq_top`

## Requirements
- R1: After reset the domain is off: `pwr_sleep`=1, `iso_en`=1, every `mem_pd` bit =1, `misc_pd`=8'hFF, `blk_rst`=1, `clk_en`=0, `busy`=0, `done`=0, `dom_on`=0.
- R2: An accepted power-up first clears `pwr_sleep`. The first memory bit changes no sooner than T_LONG_US ticks later, and isolation stays asserted while memory bits change.
- R3: Memory banks are stepped in ascending bank order (bank k occupies `mem_pd[32k+31:32k]`). Within a bank the pairs go upward from bits 1:0 to bits 31:30, one pair per step, with at least T_STEP_US ticks between steps. Power-up writes 0 and power-down writes 1.
- R4: After the banks, `misc_pd` changes one bit per step from bit 0 to bit 7, with at least T_STEP_US ticks after each step. A further T_LONG_US ticks follow the last step.
- R5: The power-up tail, on successive clock cycles, is: assert `blk_rst`, clear `iso_en`, release `blk_rst`, set `clk_en`.
- R6: An accepted power-down first sets `iso_en`, waits T_LONG_US ticks, then sets the memory bits in the same bank and pair order as R3.
- R7: After the last power-down memory step and T_LONG_US ticks, `pwr_sleep` is set. `clk_en` falls T_OFF_US ticks later.
- R8: `three_bank_mode`, sampled when a command is accepted, selects three banks when 1 and two banks when 0. Bank 2 is stepped after banks 0 and 1. In two-bank mode bank 2 never changes.
- R9: A command that arrives while `busy` is high has no effect. In idle, `cmd_up` wins when both commands are high.
- R10: A power-up command while `dom_on`=1, or a power-down command while `dom_on`=0, produces `done` on the next cycle. `busy` stays low and no other output changes.
- R11: `busy` is high from the cycle after an accepted command until the sequence ends. `done` is a one-cycle pulse in the same cycle as the final output change and the update of `dom_on`, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| three_bank_mode | input | 1 | 1: step three banks, 0: two banks |
| cmd_up | input | 1 | Power-up command pulse |
| cmd_down | input | 1 | Power-down command pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| dom_on | output | 1 | Domain is powered and clocked |
| pwr_sleep | output | 1 | Domain power switch off when 1 |
| iso_en | output | 1 | Domain outputs isolated when 1 |
| blk_rst | output | 1 | Domain reset asserted when 1 |
| clk_en | output | 1 | Domain clock enable |
| mem_pd | output | NUM_BANKS*MEM_W | Paired memory power-down bits, 1 = down |
| misc_pd | output | MISC_W | Single-step memory power-down bits, 1 = down |

## Verification
A corrupted step index or phase would show at the ports as one of two errors. Either a memory bit pair changes out of order or in the wrong direction, or a tail control moves before its predecessor. Either error appears within one step wait of the fault. A timer that loads the wrong length shows as a change that comes too early or too late, measured in ticks between successive output changes. A state that fails to return to idle shows as a missing `done` pulse, or as `busy` still high after the last expected change. A stray command shows as an output change that was not expected.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_STEP,
    ST_POST,
    ST_U_ISO,
    ST_U_DRST,
    ST_U_CLK,
    ST_D_OFF
  } psq_state_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (tick && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/psq_mem_walker.sv
module psq_mem_walker #(
  parameter int MEM_W     = 32,
  parameter int NUM_BANKS = 3,
  parameter int MISC_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       step,
  input  logic                       level,
  input  logic                       all_banks,
  output logic                       finished,
  output logic [NUM_BANKS*MEM_W-1:0] mem_pd,
  output logic [MISC_W-1:0]          misc_pd
);
  localparam int PAIRS     = MEM_W / 2;
  localparam int PAIR_TOT  = NUM_BANKS * PAIRS;
  localparam int MAX_STEPS = PAIR_TOT + MISC_W;
  localparam int IDX_W     = $clog2(MAX_STEPS + 1);

  logic [IDX_W-1:0]           idx_q;
  logic [IDX_W-1:0]           bank_steps;
  logic [IDX_W-1:0]           misc_idx;
  logic                       in_banks;
  logic [NUM_BANKS*MEM_W-1:0] mem_q, mem_d;
  logic [MISC_W-1:0]          misc_q, misc_d;

  assign bank_steps = all_banks ? IDX_W'(PAIR_TOT) : IDX_W'(PAIR_TOT - PAIRS);
  assign in_banks   = (idx_q < bank_steps);
  assign misc_idx   = idx_q - bank_steps;
  assign finished   = (idx_q == bank_steps + IDX_W'(MISC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (start) idx_q <= '0;
    else if (step)  idx_q <= idx_q + 1'b1;
  end

  // One pair or one single bit moves per step; everything else holds.
  always_comb begin
    mem_d  = mem_q;
    misc_d = misc_q;
    if (step) begin
      for (int s = 0; s < PAIR_TOT; s++)
        if (in_banks && idx_q == IDX_W'(s)) mem_d[2*s +: 2] = {2{level}};
      for (int m = 0; m < MISC_W; m++)
        if (!in_banks && misc_idx == IDX_W'(m)) misc_d[m] = level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '1;
      misc_q <= '1;
    end else begin
      mem_q  <= mem_d;
      misc_q <= misc_d;
    end
  end

  assign mem_pd  = mem_q;
  assign misc_pd = misc_q;
endmodule

// File: rtl/psq_top.sv
module psq_top
  import psq_pkg::*;
#(
  parameter int MEM_W     = 32,
  parameter int NUM_BANKS = 3,
  parameter int MISC_W    = 8,
  parameter int T_LONG_US = 20,
  parameter int T_STEP_US = 5,
  parameter int T_OFF_US  = 20000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       us_tick,
  input  logic                       three_bank_mode,
  input  logic                       cmd_up,
  input  logic                       cmd_down,
  output logic                       busy,
  output logic                       done,
  output logic                       dom_on,
  output logic                       pwr_sleep,
  output logic                       iso_en,
  output logic                       blk_rst,
  output logic                       clk_en,
  output logic [NUM_BANKS*MEM_W-1:0] mem_pd,
  output logic [MISC_W-1:0]          misc_pd
);
  localparam int CNT_W = $clog2(max3(T_LONG_US, T_STEP_US, T_OFF_US) + 1);

  psq_state_e       st_q, st_d;
  logic             dir_up_q, all_q;
  logic             sleep_q, iso_q, rst_q, clk_q, on_q, done_q;
  logic             want_up, want_dn, noop, accept;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             walk_start, walk_step, walk_fin;

  assign want_up = cmd_up;
  assign want_dn = cmd_down && !cmd_up;

  psq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(us_tick),
    .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  psq_mem_walker #(.MEM_W(MEM_W), .NUM_BANKS(NUM_BANKS), .MISC_W(MISC_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .step(walk_step),
    .level(!dir_up_q), .all_banks(all_q), .finished(walk_fin),
    .mem_pd(mem_pd), .misc_pd(misc_pd)
  );

  always_comb begin
    st_d       = st_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    walk_start = 1'b0;
    walk_step  = 1'b0;
    noop       = 1'b0;
    accept     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (want_up || want_dn) begin
          if (want_up ? on_q : !on_q) begin
            noop = 1'b1;
          end else begin
            accept     = 1'b1;
            tmr_load   = 1'b1;
            tmr_val    = CNT_W'(T_LONG_US);
            walk_start = 1'b1;
            st_d       = ST_PRE;
          end
        end
      end
      ST_PRE: begin
        if (tmr_exp) begin
          walk_step = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(T_STEP_US);
          st_d      = ST_STEP;
        end
      end
      ST_STEP: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (walk_fin) begin
            tmr_val = CNT_W'(T_LONG_US);
            st_d    = ST_POST;
          end else begin
            walk_step = 1'b1;
            tmr_val   = CNT_W'(T_STEP_US);
          end
        end
      end
      ST_POST: begin
        if (tmr_exp) begin
          if (dir_up_q) begin
            st_d = ST_U_ISO;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_OFF_US);
            st_d     = ST_D_OFF;
          end
        end
      end
      ST_U_ISO:  st_d = ST_U_DRST;
      ST_U_DRST: st_d = ST_U_CLK;
      ST_U_CLK:  st_d = ST_IDLE;
      ST_D_OFF:  if (tmr_exp) st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      dir_up_q <= 1'b0;
      all_q    <= 1'b0;
      sleep_q  <= 1'b1;
      iso_q    <= 1'b1;
      rst_q    <= 1'b1;
      clk_q    <= 1'b0;
      on_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (noop) begin
            done_q <= 1'b1;
          end else if (accept) begin
            dir_up_q <= want_up;
            all_q    <= three_bank_mode;
            if (want_up) sleep_q <= 1'b0;
            else         iso_q   <= 1'b1;
          end
        end
        ST_POST: begin
          if (tmr_exp) begin
            if (dir_up_q) rst_q   <= 1'b1;
            else          sleep_q <= 1'b1;
          end
        end
        ST_U_ISO:  iso_q <= 1'b0;
        ST_U_DRST: rst_q <= 1'b0;
        ST_U_CLK: begin
          clk_q  <= 1'b1;
          on_q   <= 1'b1;
          done_q <= 1'b1;
        end
        ST_D_OFF: begin
          if (tmr_exp) begin
            clk_q  <= 1'b0;
            on_q   <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign dom_on    = on_q;
  assign pwr_sleep = sleep_q;
  assign iso_en    = iso_q;
  assign blk_rst   = rst_q;
  assign clk_en    = clk_q;
endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
  parameter int MEM_W     = 32,
  parameter int NUM_BANKS = 3,
  parameter int MISC_W    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       done,
  input logic                       dom_on,
  input logic                       pwr_sleep,
  input logic                       iso_en,
  input logic                       blk_rst,
  input logic                       clk_en,
  input logic [NUM_BANKS*MEM_W-1:0] mem_pd,
  input logic [MISC_W-1:0]          misc_pd
);
  AST_MEM_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_pd ^ $past(mem_pd)) <= 2); // R3
  AST_MISC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(misc_pd ^ $past(misc_pd)) <= 1); // R4
  AST_MEM_UNDER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_pd) |-> (iso_en && !pwr_sleep)); // R2
  AST_ISO_DROP_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> blk_rst); // R5
  AST_CLK_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (!iso_en && !blk_rst && !pwr_sleep)); // R5
  AST_CLK_OFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> (pwr_sleep && iso_en)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_ON_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dom_on) |-> clk_en); // R11
endmodule

bind psq_top psq_checker #(.MEM_W(MEM_W), .NUM_BANKS(NUM_BANKS), .MISC_W(MISC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dom_on(dom_on),
  .pwr_sleep(pwr_sleep), .iso_en(iso_en), .blk_rst(blk_rst), .clk_en(clk_en),
  .mem_pd(mem_pd), .misc_pd(misc_pd)
);

// File: tb/tb_psq_top.sv
`timescale 1ns/1ps
module tb_psq_top;
  localparam int TL = 3;
  localparam int TS = 2;
  localparam int TOFF = 10;
  localparam int FREE = 1 << 30;

  typedef struct {
    int          id;
    logic [31:0] val;
    int          mn;
    int          mx;
    string       req;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
  logic three_bank_mode = 1'b0, cmd_up = 1'b0, cmd_down = 1'b0;
  logic busy, done, dom_on, pwr_sleep, iso_en, blk_rst, clk_en;
  logic [95:0] mem_pd;
  logic [7:0]  misc_pd;

  int checks = 0, errors = 0;
  int tick_cnt = 0, last_tick = 0, div = 0;
  int carry_mn = 0, carry_n = 0;
  bit mon_en = 1'b0;
  ev_t q[$];
  logic [31:0] exp_v [9];

  psq_top #(.T_LONG_US(TL), .T_STEP_US(TS), .T_OFF_US(TOFF)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .three_bank_mode(three_bank_mode),
    .cmd_up(cmd_up), .cmd_down(cmd_down), .busy(busy), .done(done), .dom_on(dom_on),
    .pwr_sleep(pwr_sleep), .iso_en(iso_en), .blk_rst(blk_rst), .clk_en(clk_en),
    .mem_pd(mem_pd), .misc_pd(misc_pd)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    us_tick <= (div == 2);
  end
  always @(posedge clk) if (us_tick) tick_cnt <= tick_cnt + 1;

  task automatic check(bit ok, string req, string what, logic [95:0] act, logic [95:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] obs(int id);
    case (id)
      0: return {31'b0, pwr_sleep};
      1: return {31'b0, iso_en};
      2: return {31'b0, blk_rst};
      3: return {31'b0, clk_en};
      4: return mem_pd[31:0];
      5: return mem_pd[63:32];
      6: return mem_pd[95:64];
      7: return {24'b0, misc_pd};
      default: return {31'b0, done};
    endcase
  endfunction

  // Driver side: expected output changes, with tick distance from the previous change
  task automatic ev(int id, logic [31:0] v, int mn, string req, bit free);
    ev_t it;
    if (id != 8 && v == exp_v[id]) begin
      carry_mn += mn;
      carry_n++;
      return;
    end
    it.id  = id;
    it.val = v;
    it.mn  = mn + carry_mn;
    it.mx  = free ? FREE : mn + carry_mn + 3 + carry_n;
    it.req = req;
    carry_mn = 0;
    carry_n  = 0;
    if (id != 8) exp_v[id] = v;
    q.push_back(it);
  endtask

  task automatic pulse(bit up, bit dn);
    @(negedge clk);
    cmd_up = up;
    cmd_down = dn;
    @(negedge clk);
    cmd_up = 1'b0;
    cmd_down = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R11", "busy after sequence", {95'b0, busy}, 96'd0);
  endtask

  task automatic run_seq(bit up, bit three, bit both);
    int nb = three ? 3 : 2;
    logic [31:0] v;
    carry_mn = 0;
    carry_n  = 0;
    if (up) ev(0, 32'd0, 0, "R2", 1'b1);
    else    ev(1, 32'd1, 0, "R6", 1'b1);
    for (int b = 0; b < nb; b++)
      for (int p = 0; p < 16; p++) begin
        v = exp_v[4+b];
        v[2*p +: 2] = up ? 2'b00 : 2'b11;
        ev(4 + b, v, (b == 0 && p == 0) ? TL : TS, (b == 2) ? "R8" : (up ? "R3" : "R6"), 1'b0);
      end
    for (int m = 0; m < 8; m++) begin
      v = exp_v[7];
      v[m] = !up;
      ev(7, v, TS, "R4", 1'b0);
    end
    if (up) begin
      ev(2, 32'd1, TS + TL, "R5", 1'b0);
      ev(1, 32'd0, 0, "R5", 1'b0);
      ev(2, 32'd0, 0, "R5", 1'b0);
      ev(3, 32'd1, 0, "R5", 1'b0);
    end else begin
      ev(0, 32'd1, TS + TL, "R7", 1'b0);
      ev(3, 32'd0, TOFF, "R7", 1'b0);
    end
    ev(8, 32'd1, 0, "R11", 1'b0);
    three_bank_mode = three;
    pulse(both | up, both | !up);
    check(busy == 1'b1, "R11", "busy after accept", {95'b0, busy}, 96'd1);
  endtask

  task automatic run_noop(bit up);
    carry_mn = 0;
    carry_n  = 0;
    ev(8, 32'd1, 0, "R10", 1'b1);
    pulse(up, !up);
    check(busy == 1'b0, "R10", "busy on no-op", {95'b0, busy}, 96'd0);
    drain();
  endtask

  // Monitor side: every output change is compared with the next expected item
  initial begin
    logic [31:0] prev [9];
    logic [31:0] cur;
    ev_t it;
    int d;
    wait (mon_en);
    for (int i = 0; i < 9; i++) prev[i] = obs(i);
    forever begin
      @(negedge clk);
      for (int i = 0; i < 9; i++) begin
        cur = obs(i);
        if (cur != prev[i] && !(i == 8 && cur == 32'd0)) begin
          d = tick_cnt - last_tick;
          last_tick = tick_cnt;
          if (q.size() == 0) begin
            check(1'b0, "R9", $sformatf("unexpected change on output %0d", i), {64'b0, cur}, {64'b0, prev[i]});
          end else begin
            it = q.pop_front();
            check(it.id == i && it.val == cur, it.req,
                  $sformatf("change order/value (expected output %0d, saw %0d)", it.id, i),
                  {64'b0, cur}, {64'b0, it.val});
            check(d >= it.mn && d <= it.mx, it.req,
                  $sformatf("tick distance on output %0d", i), 96'(d), 96'(it.mn));
          end
        end
        prev[i] = cur;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_v[0] = 1; exp_v[1] = 1; exp_v[2] = 1; exp_v[3] = 0;
    exp_v[4] = '1; exp_v[5] = '1; exp_v[6] = '1; exp_v[7] = 32'hFF; exp_v[8] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({pwr_sleep, iso_en, blk_rst, clk_en} == 4'b1110, "R1", "control levels",
          {92'b0, pwr_sleep, iso_en, blk_rst, clk_en}, 96'hE);
    check(mem_pd == '1, "R1", "mem_pd", mem_pd, '1);
    check(misc_pd == 8'hFF, "R1", "misc_pd", {88'b0, misc_pd}, 96'hFF);
    check({busy, done, dom_on} == 3'b000, "R1", "busy/done/dom_on", {93'b0, busy, done, dom_on}, 96'd0);
    last_tick = tick_cnt;
    mon_en = 1'b1;

    run_noop(1'b0);                          // R10: down while off
    run_seq(1'b1, 1'b0, 1'b1);               // R9: both commands, up wins
    repeat (30) @(negedge clk);
    three_bank_mode = 1'b1;                  // R8: latched, no effect mid-sequence
    pulse(1'b0, 1'b1);                       // R9: ignored while busy
    pulse(1'b1, 1'b0);                       // R9: ignored while busy
    drain();
    check(dom_on == 1'b1, "R11", "dom_on after up", {95'b0, dom_on}, 96'd1);
    check(mem_pd[95:64] == '1, "R8", "bank 2 untouched in two-bank up", {64'b0, mem_pd[95:64]}, {64'b0, 32'hFFFFFFFF});
    run_noop(1'b1);                          // R10: up while on
    run_seq(1'b0, 1'b1, 1'b0);  drain();     // down, three banks
    check(dom_on == 1'b0, "R11", "dom_on after down", {95'b0, dom_on}, 96'd0);
    run_seq(1'b1, 1'b1, 1'b0);  drain();     // up, three banks
    check(mem_pd == '0, "R8", "all three banks cleared", mem_pd, 96'd0);
    run_seq(1'b0, 1'b0, 1'b0);  drain();     // down, two banks
    check(mem_pd[95:64] == '0, "R8", "bank 2 kept in two-bank down", {64'b0, mem_pd[95:64]}, 96'd0);
    run_seq(1'b1, 1'b0, 1'b0);  drain();     // up, two banks
    check(q.size() == 0, "R11", "expected changes left", 96'(q.size()), 96'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule